// File: doc/BRIEF.md
# Bus Transmit-Check Error Monitor

This block sits next to a node's drivers on a shared bus and confirms that what the node puts on the bus is what the bus actually carries. Every cycle it compares the values it drove against the values it reads back. There are two kinds of comparison. Fields that only this node drives, in known cycles, get an exact level comparison. Signals that several nodes may drive, or whose assertion sets timing, get an assertion-only comparison. The node's 3-bit command field is level-compared only in cycles when the node is sending a command.

The block also checks parity on the received command and address fields. It does this only for cycles marked by a valid-transaction strobe, because those fields carry no defined value on an idle bus. Each error class sets its own sticky status bit, and the bit stays set until software pulses a clear. Address-bus problems usually mean the nodes disagree about bus state, which is fatal to the system. For that reason each detected error can also raise a one-cycle fault pulse, gated by a fault-enable control.

Top module: `xmit_chk_mon`

## Requirements
- R1: While `cmd_oe_i` is 1, any difference between `cmd_drv_i` and `cmd_bus_i` sets `err_lvl_o` on the next clock edge. While `cmd_oe_i` is 0, differences on the command field are ignored.
- R2: A bit of the level group whose `lvl_oe_i` bit is 1 and whose read-back differs from the driven value sets `err_lvl_o` on the next edge. This holds whether the driven value was 1 or 0. Bits with `lvl_oe_i` at 0 are not compared.
- R3: An assertion-checked bit that is driven 1 and read back 0 sets `err_asrt_o` on the next edge. A bit driven 0 and read back 1 is not an error.
- R4: When `addr_vld_i` is 1, the block captures the received `cmd_bus_i`, `addr_bus_i` and `par_bus_i` in registers. In the following cycle it evaluates even parity over them: the XOR of all captured bits must be 0. A parity failure sets `err_par_o` two edges after the strobe edge.
- R5: When `addr_vld_i` is 0, the block flags no parity error, whatever the bus fields hold.
- R6: Each status bit stays at 1 until a clear, even after its cause has gone.
- R7: A one-cycle `sw_clr_i` clears all three status bits. If an error is detected in the same cycle as the clear, the error wins and its bit stays set.
- R8: While `fault_en_i` is 1, each cycle in which any error is detected makes `fault_o` high for exactly one cycle, on the next edge. While `fault_en_i` is 0, `fault_o` stays 0.
- R9: After reset, all status bits and `fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_oe_i | input | 1 | Node is sending a command this cycle |
| cmd_drv_i | input | CMD_W | Command value driven |
| cmd_bus_i | input | CMD_W | Command value read from the bus |
| lvl_oe_i | input | LVL_W | Per-bit drive enable of the single-driver group |
| lvl_drv_i | input | LVL_W | Single-driver group, driven values |
| lvl_bus_i | input | LVL_W | Single-driver group, bus values |
| asrt_drv_i | input | ASRT_W | Shared/timing signals driven asserted (1) |
| asrt_bus_i | input | ASRT_W | Shared/timing signals read from the bus |
| addr_vld_i | input | 1 | Valid address-bus transaction strobe |
| addr_bus_i | input | ADDR_W | Address field read from the bus |
| par_bus_i | input | 1 | Parity bit read from the bus |
| sw_clr_i | input | 1 | Software clear pulse for all status bits |
| fault_en_i | input | 1 | Enables the fault pulse |
| err_lvl_o | output | 1 | Sticky level-check error |
| err_asrt_o | output | 1 | Sticky assertion-check error |
| err_par_o | output | 1 | Sticky address parity error |
| fault_o | output | 1 | One-cycle system fault pulse |

## Verification
The assertions check the following on every cycle:
- a command mismatch while sending, or an asserted-but-lost signal, sets its status bit on the next edge;
- status bits hold without a clear, and an error in the clear cycle still sets its bit;
- a fault pulse only follows a detection made with faults enabled;
- a parity flag rises only two edges after a strobe.

Only the directed scenarios can show the cases where nothing should happen. These are mismatches on bits that are not enabled, a wire driven low and read back high, and bad parity on an idle bus. The scenarios also show correct parity evaluation on concrete field values and the exact one-cycle width of the fault pulse.

// File: rtl/xcm_pkg.sv
package xcm_pkg;
  localparam int unsigned ERR_LVL  = 0;
  localparam int unsigned ERR_ASRT = 1;
  localparam int unsigned ERR_PAR  = 2;
  localparam int unsigned NUM_ERR  = 3;
  typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/xcm_level_chk.sv
module xcm_level_chk #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] drv_i,
  input  logic [W-1:0] oe_i,
  input  logic [W-1:0] bus_i,
  output logic         mis_o
);
  logic [W-1:0] bit_mis;
  for (genvar i = 0; i < W; i++) begin : g_bit
    // exact level compare on enabled bits
    assign bit_mis[i] = oe_i[i] & (drv_i[i] ^ bus_i[i]);
  end
  assign mis_o = |bit_mis;
endmodule

// File: rtl/xcm_asrt_chk.sv
module xcm_asrt_chk #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] drv_i,
  input  logic [W-1:0] bus_i,
  output logic         mis_o
);
  logic [W-1:0] bit_mis;
  for (genvar i = 0; i < W; i++) begin : g_bit
    // only a lost assertion counts
    assign bit_mis[i] = drv_i[i] & ~bus_i[i];
  end
  assign mis_o = |bit_mis;
endmodule

// File: rtl/xcm_par_chk.sv
module xcm_par_chk #(
  parameter int unsigned CMD_W  = 3,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              par_i,
  output logic              perr_o
);
  logic              vld_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
      par_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        cmd_q  <= cmd_i;
        addr_q <= addr_i;
        par_q  <= par_i;
      end
    end
  end

  // even parity: XOR of all captured bits is zero when good
  assign perr_o = vld_q & (^{cmd_q, addr_q, par_q});
endmodule

// File: rtl/xcm_err_status.sv
module xcm_err_status
  import xcm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  err_vec_t det_i,
  input  logic     clr_i,
  input  logic     fault_en_i,
  output err_vec_t sts_o,
  output logic     fault_o
);
  err_vec_t sts_q;
  logic     fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      // new detection beats a same-cycle clear
      sts_q   <= det_i | (sts_q & ~{NUM_ERR{clr_i}});
      fault_q <= fault_en_i & (|det_i);
    end
  end

  assign sts_o   = sts_q;
  assign fault_o = fault_q;

  assert_sticky_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
  assert_clr_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && det_i == '0) |=> (sts_q == '0));
  assert_det_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i != '0) |=> ((sts_q & $past(det_i)) == $past(det_i)));
  assert_fault_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> $past(fault_en_i && (det_i != '0)));
  assert_fault_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_en_i |=> !fault_q);
endmodule

// File: rtl/xmit_chk_mon.sv
module xmit_chk_mon
  import xcm_pkg::*;
#(
  parameter int unsigned CMD_W  = 3,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned ASRT_W = 4,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_oe_i,
  input  logic [CMD_W-1:0]  cmd_drv_i,
  input  logic [CMD_W-1:0]  cmd_bus_i,
  input  logic [LVL_W-1:0]  lvl_oe_i,
  input  logic [LVL_W-1:0]  lvl_drv_i,
  input  logic [LVL_W-1:0]  lvl_bus_i,
  input  logic [ASRT_W-1:0] asrt_drv_i,
  input  logic [ASRT_W-1:0] asrt_bus_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_bus_i,
  input  logic              par_bus_i,
  input  logic              sw_clr_i,
  input  logic              fault_en_i,
  output logic              err_lvl_o,
  output logic              err_asrt_o,
  output logic              err_par_o,
  output logic              fault_o
);
  logic     cmd_mis, lvl_mis, asrt_mis, par_err;
  err_vec_t det, sts;

  xcm_level_chk #(.W(CMD_W)) u_cmd_chk (
    .drv_i (cmd_drv_i),
    .oe_i  ({CMD_W{cmd_oe_i}}),
    .bus_i (cmd_bus_i),
    .mis_o (cmd_mis)
  );

  xcm_level_chk #(.W(LVL_W)) u_lvl_chk (
    .drv_i (lvl_drv_i),
    .oe_i  (lvl_oe_i),
    .bus_i (lvl_bus_i),
    .mis_o (lvl_mis)
  );

  xcm_asrt_chk #(.W(ASRT_W)) u_asrt_chk (
    .drv_i (asrt_drv_i),
    .bus_i (asrt_bus_i),
    .mis_o (asrt_mis)
  );

  xcm_par_chk #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_par_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (addr_vld_i),
    .cmd_i  (cmd_bus_i),
    .addr_i (addr_bus_i),
    .par_i  (par_bus_i),
    .perr_o (par_err)
  );

  always_comb begin
    det           = '0;
    det[ERR_LVL]  = cmd_mis | lvl_mis;
    det[ERR_ASRT] = asrt_mis;
    det[ERR_PAR]  = par_err;
  end

  xcm_err_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_i      (det),
    .clr_i      (sw_clr_i),
    .fault_en_i (fault_en_i),
    .sts_o      (sts),
    .fault_o    (fault_o)
  );

  assign err_lvl_o  = sts[ERR_LVL];
  assign err_asrt_o = sts[ERR_ASRT];
  assign err_par_o  = sts[ERR_PAR];

  assert_cmd_level_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_oe_i && (cmd_drv_i != cmd_bus_i)) |=> err_lvl_o);
  assert_field_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lvl_oe_i & (lvl_drv_i ^ lvl_bus_i)) != '0) |=> err_lvl_o);
  assert_lost_assert_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((asrt_drv_i & ~asrt_bus_i) != '0) |=> err_asrt_o);
  assert_par_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_par_o) |-> $past(addr_vld_i, 2));
endmodule

// File: tb/xmit_chk_mon_tb.sv
module xmit_chk_mon_tb;
  localparam int unsigned CMD_W = 3, LVL_W = 4, ASRT_W = 4, ADDR_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_oe;
  logic [CMD_W-1:0] cmd_drv, cmd_bus;
  logic [LVL_W-1:0] lvl_oe, lvl_drv, lvl_bus;
  logic [ASRT_W-1:0] asrt_drv, asrt_bus;
  logic addr_vld;
  logic [ADDR_W-1:0] addr_bus;
  logic par_bus, sw_clr, fault_en;
  logic err_lvl, err_asrt, err_par, fault;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xmit_chk_mon #(.CMD_W(CMD_W), .LVL_W(LVL_W), .ASRT_W(ASRT_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_oe_i(cmd_oe), .cmd_drv_i(cmd_drv), .cmd_bus_i(cmd_bus),
    .lvl_oe_i(lvl_oe), .lvl_drv_i(lvl_drv), .lvl_bus_i(lvl_bus),
    .asrt_drv_i(asrt_drv), .asrt_bus_i(asrt_bus),
    .addr_vld_i(addr_vld), .addr_bus_i(addr_bus), .par_bus_i(par_bus),
    .sw_clr_i(sw_clr), .fault_en_i(fault_en),
    .err_lvl_o(err_lvl), .err_asrt_o(err_asrt), .err_par_o(err_par), .fault_o(fault)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {err_lvl, err_asrt, err_par, fault};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cmd_oe = 0; cmd_drv = '0; cmd_bus = '0;
    lvl_oe = '0; lvl_drv = '0; lvl_bus = '0;
    asrt_drv = '0; asrt_bus = '0;
    addr_vld = 0; addr_bus = '0; par_bus = 0;
    sw_clr = 0;
  endtask

  task automatic clear();
    sw_clr = 1; step(); sw_clr = 0;
  endtask

  task automatic t_reset();
    check("R9 reset state", outs(), 4'b0000);
  endtask

  task automatic t_cmd();
    idle(); fault_en = 0;
    cmd_oe = 0; cmd_drv = 3'b101; cmd_bus = 3'b100; step();
    check("R1 cmd mismatch ignored when not sending", outs(), 4'b0000);
    cmd_oe = 1; cmd_drv = 3'b011; cmd_bus = 3'b011; step();
    check("R1 cmd match while sending", outs(), 4'b0000);
    cmd_bus = 3'b111; step(); idle();
    check("R1 cmd mismatch while sending", outs(), 4'b1000);
    clear();
  endtask

  task automatic t_lvl();
    idle();
    lvl_oe = 4'b0010; lvl_drv = 4'b0000; lvl_bus = 4'b1101; step();
    check("R2 disabled bits not compared", outs(), 4'b0000);
    lvl_bus = 4'b0010; step(); idle();
    check("R2 driven low read high", outs(), 4'b1000);
    clear();
    lvl_oe = 4'b1000; lvl_drv = 4'b1000; lvl_bus = 4'b0000; step(); idle();
    check("R2 driven high read low", outs(), 4'b1000);
    clear();
  endtask

  task automatic t_asrt();
    idle();
    asrt_drv = 4'b0000; asrt_bus = 4'b1111; step();
    check("R3 other driver asserting is fine", outs(), 4'b0000);
    asrt_drv = 4'b0100; asrt_bus = 4'b0110; step();
    check("R3 assertion seen", outs(), 4'b0000);
    asrt_drv = 4'b0100; asrt_bus = 4'b1011; step(); idle();
    check("R3 assertion lost", outs(), 4'b0100);
    clear();
  endtask

  task automatic t_par();
    idle();
    addr_vld = 1; cmd_bus = 3'b001; addr_bus = 16'h0000; par_bus = 1; step();
    addr_vld = 0; step();
    check("R4 good even parity", outs(), 4'b0000);
    addr_vld = 1; cmd_bus = 3'b000; addr_bus = 16'h8001; par_bus = 1; step();
    addr_vld = 0; cmd_bus = 3'b000; par_bus = 0;
    check("R4 not yet flagged one edge after strobe", outs(), 4'b0000);
    step();
    check("R4 bad parity flagged", outs(), 4'b0010);
    clear();
    addr_vld = 0; cmd_bus = 3'b001; addr_bus = 16'h0000; par_bus = 0;
    step(); step(); step();
    check("R5 idle bus garbage not flagged", outs(), 4'b0000);
    idle();
  endtask

  task automatic t_sticky_clear();
    idle(); fault_en = 0;
    cmd_oe = 1; cmd_drv = 3'b010; cmd_bus = 3'b000;
    asrt_drv = 4'b0001; asrt_bus = 4'b0000; step(); idle();
    step(); step(); step();
    check("R6 status holds after cause gone", outs(), 4'b1100);
    sw_clr = 1; asrt_drv = 4'b0001; asrt_bus = 4'b0000; step(); idle();
    check("R7 same-cycle error beats clear", outs(), 4'b0100);
    clear();
    check("R7 clear empties all bits", outs(), 4'b0000);
  endtask

  task automatic t_fault();
    idle(); fault_en = 0;
    asrt_drv = 4'b1000; step(); idle();
    check("R8 no pulse when disabled", outs(), 4'b0100);
    clear();
    fault_en = 1;
    asrt_drv = 4'b1000; step(); idle();
    check("R8 pulse after detection", outs(), 4'b0101);
    step();
    check("R8 pulse lasts one cycle", outs(), 4'b0100);
    clear();
    addr_vld = 1; cmd_bus = 3'b001; par_bus = 0; step(); idle(); step();
    check("R8 parity error pulses fault", outs(), 4'b0011);
    fault_en = 0;
    clear();
  endtask

  initial begin
    fault_en = 0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_ni = 1;
    step();
    t_reset();
    t_cmd();
    t_lvl();
    t_asrt();
    t_par();
    t_sticky_clear();
    t_fault();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule